// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block paces the slow control events of a retro sound generator. It counts clock-enable pulses issued at the processor rate. At each step boundary it emits a one-cycle quarter-frame strobe, which drives the envelope and linear counters. On two of the four step slots it also emits a half-frame strobe, which drives the length counters and the sweep units. The nominal step length is `STEP_PERIOD` enables, but the steps are not all the same length. The step that follows step 1 arrives two enables early. In 5-step mode the final slot is stretched by almost a whole extra period.

Software writes a mode byte. Bit 7 selects 5-step mode and bit 6 inhibits the frame interrupt. Every mode write restarts the sequence:
- In 5-step mode the sequence restarts from step 0, so a quarter-frame strobe and a half-frame strobe fire on the very next enable.
- In 4-step mode it restarts from step 1, one full period away.

In 4-step mode with the interrupt allowed, a separate down-counter times the frame interrupt. It is armed by each mode write and reloaded at every step 0. An all-ones value in this counter means that no interrupt is scheduled. A status-read strobe returns the interrupt flag in bit 6 of the status byte and clears the flag.

Top module: `frame_seq_irq`

## Requirements
- R1: Reset is synchronous and active high. It puts the block in 4-step mode with the interrupt allowed, as if mode byte 0x00 had just been written. While reset is held and in the cycle after it, `qtr_stb`, `half_stb` and `irq` are 0 and `stat_rdata` is 0x00.
- R2: Step boundaries fall on enables only. Counted in enables, the distance from step 0 to 1 is P+1, from 1 to 2 is P-1, from 2 to 3 is P+1, and in 4-step mode from 3 back to 0 is P+1, where P is `STEP_PERIOD`. Each boundary gives a one-cycle `qtr_stb` in the cycle after that enable's edge.
- R3: `half_stb` pulses together with `qtr_stb` on steps 0 and 2 only, and never on its own.
- R4: A mode write with bit 7 set selects 5-step mode. Step 0 (quarter plus half) then fires on the first enable after the write. In this mode the step 3 to step 0 distance is 2P-5 enables.
- R5: A mode write with bit 7 clear selects 4-step mode. The sequence restarts at step 1, with the first quarter strobe P+1 enables after the write.
- R6: In 4-step mode with bit 6 clear, the frame flag (`irq`) rises 4P-2 enables after the mode write. The interrupt counter is reloaded at each step 0, and the flag rises again 4P+2 enables later, which is on the next step 0.
- R7: A mode write with bit 6 set clears the flag on that write's edge and schedules no interrupt.
- R8: A `stat_rd` cycle clears the flag, and `stat_rdata` bit 6 shows the flag. If a read and a flag set land on the same edge, the set wins.
- R9: While `ce` is low, nothing advances and no strobe or flag rise occurs.
- R10: A mode write cancels the pending schedule, and its own edge emits no strobe.
- R11: In 5-step mode the flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Processor-rate clock enable |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte: bit 7 selects 5-step, bit 6 inhibits the interrupt |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| stat_rdata | output | 8 | Status byte, flag in bit 6 |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq | output | 1 | Frame interrupt flag |

## Verification
A wrong step index or a wrong reload value shows up as a strobe that arrives early or late, or as a half strobe on the wrong slot. The bench sees this at the very next boundary, no more than about 2P enables later. A wrong interrupt counter shows up as `irq` rising a few cycles off the expected edge, or not at all. This is checked on the exact edge, both for the first rise after a write and for the reload at step 0. A lost inhibit, clear or mode bit shows up in the cycle after the write or read.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int MODE_FIVE_BIT = 7;
    localparam int MODE_INH_BIT  = 6;
    localparam int STAT_IRQ_BIT  = 6;

    typedef enum logic [1:0] {
        STEP0 = 2'd0,
        STEP1 = 2'd1,
        STEP2 = 2'd2,
        STEP3 = 2'd3
    } fseq_step_e;

    typedef struct packed {
        logic five_step;
        logic irq_inhibit;
    } fseq_mode_t;

    typedef struct packed {
        logic quarter;
        logic half;
    } fseq_tick_t;

    function automatic fseq_mode_t decode_mode(input logic [7:0] b);
        fseq_mode_t m;
        m.five_step   = b[MODE_FIVE_BIT];
        m.irq_inhibit = b[MODE_INH_BIT];
        return m;
    endfunction

    function automatic fseq_step_e next_step(input fseq_step_e s);
        case (s)
            STEP0:   return STEP1;
            STEP1:   return STEP2;
            STEP2:   return STEP3;
            default: return STEP0;
        endcase
    endfunction

    // Delay loaded when step s fires; the next step comes this many plus one enables later.
    function automatic int unsigned reload_after(input fseq_step_e s, input logic five,
                                                 input int unsigned period);
        case (s)
            STEP1:   return period - 2;
            STEP3:   return five ? (2 * period - 6) : period;
            default: return period;
        endcase
    endfunction

    function automatic logic is_half_slot(input fseq_step_e s);
        return (s == STEP0) || (s == STEP2);
    endfunction

endpackage

// File: rtl/fseq_step_timer.sv
module fseq_step_timer
    import fseq_pkg::*;
#(
    parameter int unsigned STEP_PERIOD = 7458,
    parameter int unsigned CNT_W       = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       mode_wr,
    input  logic       five_new,
    input  logic       five_cur,
    output fseq_tick_t tick,
    output logic       step0_now
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(STEP_PERIOD);

    logic [CNT_W-1:0] dly_q;
    fseq_step_e       idx_q;
    fseq_tick_t       tick_q;
    logic             expire;

    assign expire    = ce && !mode_wr && (dly_q == '0);
    assign step0_now = expire && (idx_q == STEP0);
    assign tick      = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= STEP1;
            dly_q  <= FULL;
            tick_q <= '0;
        end else begin
            tick_q <= '0;
            if (mode_wr) begin
                if (five_new) begin
                    idx_q <= STEP0;
                    dly_q <= '0;
                end else begin
                    idx_q <= STEP1;
                    dly_q <= FULL;
                end
            end else if (ce) begin
                if (dly_q != '0) begin
                    dly_q <= dly_q - CNT_W'(1);
                end else begin
                    tick_q.quarter <= 1'b1;
                    tick_q.half    <= is_half_slot(idx_q);
                    idx_q          <= next_step(idx_q);
                    dly_q          <= CNT_W'(reload_after(idx_q, five_cur, STEP_PERIOD));
                end
            end
        end
    end

endmodule

// File: rtl/fseq_irq_timer.sv
module fseq_irq_timer #(
    parameter int unsigned STEP_PERIOD = 7458,
    parameter int unsigned CNT_W       = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic mode_wr,
    input  logic arm_new,
    input  logic inh_new,
    input  logic load_step0,
    input  logic rd,
    output logic flag
);

    localparam logic [CNT_W-1:0] IDLE       = '1;
    localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(4 * STEP_PERIOD - 2);
    localparam logic [CNT_W-1:0] STEP_LOAD  = CNT_W'(4 * STEP_PERIOD + 2);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             fire;

    assign fire = ce && !mode_wr && (cnt_q == ONE);
    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= WRITE_LOAD;
            flag_q <= 1'b0;
        end else if (mode_wr) begin
            cnt_q  <= arm_new ? WRITE_LOAD : IDLE;
            flag_q <= flag_q && !inh_new && !rd;
        end else begin
            if (ce) begin
                if (load_step0)
                    cnt_q <= STEP_LOAD;
                else if (cnt_q != IDLE)
                    cnt_q <= (cnt_q == ONE) ? IDLE : cnt_q - ONE;
            end
            flag_q <= fire || (flag_q && !rd);
        end
    end

endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq
    import fseq_pkg::*;
#(
    parameter int unsigned STEP_PERIOD = 7458,
    parameter int unsigned CNT_W       = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       mode_wr,
    input  logic [7:0] mode_wdata,
    input  logic       stat_rd,
    output logic [7:0] stat_rdata,
    output logic       qtr_stb,
    output logic       half_stb,
    output logic       irq
);

    fseq_mode_t mode_q;
    fseq_mode_t mode_new;
    fseq_tick_t tick;
    logic       step0_now;
    logic       load_step0;
    logic       flag;

    assign mode_new = decode_mode(mode_wdata);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= mode_new;
    end

    fseq_step_timer #(
        .STEP_PERIOD (STEP_PERIOD),
        .CNT_W       (CNT_W)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .mode_wr   (mode_wr),
        .five_new  (mode_new.five_step),
        .five_cur  (mode_q.five_step),
        .tick      (tick),
        .step0_now (step0_now)
    );

    assign load_step0 = step0_now && !mode_q.five_step && !mode_q.irq_inhibit;

    fseq_irq_timer #(
        .STEP_PERIOD (STEP_PERIOD),
        .CNT_W       (CNT_W)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .mode_wr    (mode_wr),
        .arm_new    (!mode_new.five_step && !mode_new.irq_inhibit),
        .inh_new    (mode_new.irq_inhibit),
        .load_step0 (load_step0),
        .rd         (stat_rd),
        .flag       (flag)
    );

    assign qtr_stb    = tick.quarter;
    assign half_stb   = tick.half;
    assign irq        = flag;
    assign stat_rdata = 8'(flag) << STAT_IRQ_BIT;

endmodule

// File: rtl/frame_seq_irq_chk.sv
module frame_seq_irq_chk (
    input logic clk,
    input logic rst,
    input logic ce,
    input logic mode_wr,
    input logic wr_inhibit,
    input logic stat_rd,
    input logic qtr_stb,
    input logic half_stb,
    input logic irq,
    input logic five_cur
);

    p_half_with_qtr_r3: assert property (@(posedge clk) disable iff (rst)
        half_stb |-> qtr_stb);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        qtr_stb |=> !qtr_stb);

    // R9 and R10: no strobe after an edge without an enable or with a write
    p_no_tick_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!ce || mode_wr) |-> (!qtr_stb && !half_stb));

    p_inhibit_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_inhibit) |=> !irq);

    p_rise_on_enable_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(ce) && !$past(mode_wr)));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !ce) |=> !irq);

    p_five_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (five_cur && !irq) |=> !irq);

endmodule

bind frame_seq_irq frame_seq_irq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .mode_wr    (mode_wr),
    .wr_inhibit (mode_wdata[6]),
    .stat_rd    (stat_rd),
    .qtr_stb    (qtr_stb),
    .half_stb   (half_stb),
    .irq        (irq),
    .five_cur   (mode_q.five_step)
);

// File: tb/frame_seq_irq_tb_top.sv
`timescale 1ns/100ps
module frame_seq_irq_tb_top;

    localparam int P = 7458;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       qtr_stb, half_stb, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    cyc;
        bit    half;
        string req;
    } exp_t;

    exp_t exq[$];
    exp_t cur;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    frame_seq_irq #(.STEP_PERIOD(P), .CNT_W(15)) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .qtr_stb(qtr_stb), .half_stb(half_stb), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic push(input int c, input bit h, input string req);
        exp_t e;
        e.cyc = c;
        e.half = h;
        e.req = req;
        exq.push_back(e);
    endtask

    // Driver: issues a mode write, optional enable gap, and queues the strobe schedule.
    task automatic mode_write(input logic [7:0] d, input int gap, output int w);
        int b;
        @(negedge clk);
        exq.delete();
        mode_wr = 1'b1;
        mode_wdata = d;
        w = cyc + 1;
        b = w + gap;
        if (d[7]) begin
            push(b + 1,         1'b1, "R4");
            push(b + P + 2,     1'b0, "R2");
            push(b + 2*P + 1,   1'b1, "R3");
            push(b + 3*P + 2,   1'b0, "R2");
            push(b + 5*P - 3,   1'b1, "R4");
            push(b + 6*P - 2,   1'b0, "R4");
            push(b + 7*P - 3,   1'b1, "R3");
        end else begin
            push(b + P + 1,     1'b0, "R5");
            push(b + 2*P,       1'b1, "R3");
            push(b + 3*P + 1,   1'b0, "R2");
            push(b + 4*P + 2,   1'b1, "R2");
            push(b + 5*P + 3,   1'b0, "R2");
            push(b + 6*P + 2,   1'b1, "R3");
            push(b + 7*P + 3,   1'b0, "R2");
            push(b + 8*P + 4,   1'b1, "R2");
        end
        @(negedge clk);
        mode_wr = 1'b0;
        if (gap > 0) begin
            ce = 1'b0;
            repeat (gap) @(negedge clk);
            ce = 1'b1;
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compares strobes against the queued schedule.
    always begin
        @(posedge clk);
        #2;
        if (mon_en) begin
            while (exq.size() > 0 && exq[0].cyc < cyc) begin
                cur = exq.pop_front();
                chk(1'b0, cur.req, -1, cur.cyc);
            end
            if (qtr_stb || half_stb) begin
                if (exq.size() > 0 && exq[0].cyc == cyc) begin
                    cur = exq.pop_front();
                    chk(qtr_stb && (half_stb == cur.half), cur.req,
                        int'({qtr_stb, half_stb}), int'({1'b1, cur.half}));
                end else begin
                    chk(1'b0, "R10 unexpected strobe", int'({qtr_stb, half_stb}), 0);
                end
            end
        end
    end

    initial begin
        int w;
        repeat (4) @(negedge clk);
        chk(qtr_stb == 1'b0 && half_stb == 1'b0, "R1 strobes in reset", int'({qtr_stb, half_stb}), 0);
        chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(stat_rdata == 8'h00, "R1 status after reset", int'(stat_rdata), 0);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        mon_en = 1'b1;

        // 4-step, interrupt allowed
        mode_write(8'h00, 0, w);
        wait_cyc(w + 4*P - 3);
        chk(irq == 1'b0, "R6 irq before first rise", int'(irq), 0);
        stat_rd = 1'b1;                 // read lands on the set edge
        @(negedge clk);
        stat_rd = 1'b0;
        chk(irq == 1'b1, "R8 set wins over read", int'(irq), 1);
        chk(stat_rdata == 8'h40, "R8 status bit 6", int'(stat_rdata), 8'h40);
        wait_cyc(w + 4*P + 9);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(irq == 1'b0, "R8 read clears flag", int'(irq), 0);
        wait_cyc(w + 8*P + 3);
        chk(irq == 1'b0, "R6 irq before step-0 reload expiry", int'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R6 irq at next step 0", int'(irq), 1);

        // 4-step, inhibited, with a 100-cycle enable gap
        mode_write(8'h40, 100, w);
        chk(irq == 1'b0, "R7 inhibit clears flag", int'(irq), 0);
        wait_cyc(w + 100 + 5*P);
        chk(irq == 1'b0, "R7 no irq while inhibited", int'(irq), 0);
        chk(exq.size() > 0 && exq[0].cyc > cyc, "R9 schedule shifted by gap", exq.size(), 1);

        // 5-step
        mode_write(8'h80, 0, w);
        wait_cyc(w + 7*P);
        chk(irq == 1'b0, "R11 no irq in 5-step", int'(irq), 0);

        mon_en = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule